// File: doc/BRIEF.md
# External Interrupt Trigger and Grouping

This block takes twenty-four asynchronous interrupt pins and turns each into a request according to a trigger selected per pin. The choices are low level, high level, falling edge, rising edge, or either edge. The four lowest pins are passed straight through as individual parent requests once they have been qualified. Pins 4 to 23 instead latch their events into sticky pending bits. Those bits are gated by per-pin mask bits and merged into two shared parent requests: one for pins 4 to 7 and one for pins 8 to 23.

Software sees the block through a small synchronous register bus with a combinational read path. There are three trigger-configuration words, one pending word cleared by writing ones, and one mask word. A handler reads the pending word to find which pin fired, clears that bit, and leaves the other bits alone. For level triggers, the pending bit keeps re-arming for as long as the pin stays in its active level.

Top module: `eirq_top`

## Requirements
- R1: Word addresses 0, 1 and 2 hold the trigger codes for pins 0-7, 8-15 and 16-23. Pin i uses bits [4*(i%8)+2 : 4*(i%8)] of word i/8. Bit 3 of every nibble reads as zero. A written code reads back unchanged.
- R2: Trigger code 000 selects active-low level and 001 selects active-high level. Codes 010 and 011 select falling edge, 100 and 101 select rising edge, and 110 and 111 select both edges.
- R3: A pin value captured at clock edge k reaches the qualified event after edge k+1, through a two-stage synchroniser. An edge event lasts exactly one cycle. A level event holds while the level holds.
- R4: For pins 4-23, an event sets the pending bit (word address 3) at the next clock edge, whatever the mask bit is.
- R5: Writing the pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. An event in the same cycle as the clear wins, so a level trigger whose level is still present stays pending.
- R6: The lower group request is high exactly when some pin 4-7 has its pending bit at 1 and its mask bit at 0.
- R7: The upper group request is high exactly when some pin 8-23 has its pending bit at 1 and its mask bit at 0.
- R8: Pins 0-3 drive their own direct request lines and never appear in the pending word. Mask bits 0-3 always read 0.
- R9: After reset, the mask word reads 0x00FFFFF0 and the pending word reads 0. All trigger codes are 000. The synchroniser state holds the idle-high pin level, so idle-high pins raise no request.
- R10: Word addresses 5-7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pin | input | 24 | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq_direct | output | 4 | Qualified requests of pins 0-3 |
| irq_grp_lo | output | 1 | Merged request for pins 4-7 |
| irq_grp_hi | output | 1 | Merged request for pins 8-23 |

## Verification
The bench sweeps all twenty-four pins against all eight trigger codes. It drives a falling transition and then a rising one, and counts how many cycles each direct line is high. This count tells the two levels and the three edge kinds apart, so a decoder that ignored the low code bit, swapped polarity or stretched a pulse would give a wrong count. For grouped pins it compares the whole pending word with a single bit, which catches a field or pending bit placed at the wrong position or routed to the wrong group line. It also clears the pending word while a level is held, so a design that let the clear win would drop a live request. A directed pass masks one grouped pin while another stays live, clears one of two pending bits, and writes the unused addresses, which catches mask leakage, clearing on zeros and aliased decoding.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int DATA_W = 32;
  localparam int TRG_W  = 3;
  localparam int NIB_W  = 4;
  localparam int SLOTS  = DATA_W / NIB_W;

  typedef enum logic [1:0] {
    TK_LEVEL = 2'b00,
    TK_FALL  = 2'b01,
    TK_RISE  = 2'b10,
    TK_BOTH  = 2'b11
  } trg_kind_e;

  function automatic trg_kind_e trg_kind(input logic [TRG_W-1:0] code);
    return trg_kind_e'(code[2:1]);
  endfunction
endpackage

// File: rtl/eirq_rst_sync.sv
module eirq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;
  logic [1:0] stage_nxt;

  assign stage_nxt = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= stage_nxt;
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int   N    = 24,
  parameter logic IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta_q;
  logic [N-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {N{IDLE}};
      stab_q <= {N{IDLE}};
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter int   N    = 24,
  parameter logic IDLE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       lvl,
  input  logic [N*TRG_W-1:0] cfg_flat,
  output logic [N-1:0]       evt
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_nxt;

  assign prev_nxt = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= {N{IDLE}};
    else        prev_q <= prev_nxt;
  end

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [TRG_W-1:0] code;
    logic             rise;
    logic             fall;

    assign code = cfg_flat[g*TRG_W +: TRG_W];
    assign rise = lvl[g] & ~prev_q[g];
    assign fall = ~lvl[g] & prev_q[g];

    always_comb begin
      unique case (trg_kind(code))
        TK_LEVEL: evt[g] = code[0] ? lvl[g] : ~lvl[g];
        TK_FALL:  evt[g] = fall;
        TK_RISE:  evt[g] = rise;
        default:  evt[g] = rise | fall;
      endcase
    end
  end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int N      = 24,
  parameter int NDIR   = 4,
  parameter int NCFG   = 3,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [N-1:0]       evt,
  output logic [N*TRG_W-1:0] cfg_flat,
  output logic [N-1:0]       pend_q,
  output logic [N-1:0]       mask_q
);
  localparam int PEND_ADDR = NCFG;
  localparam int MASK_ADDR = NCFG + 1;
  localparam logic [N-1:0] EXT_BITS = {N{1'b1}} << NDIR;

  logic                      wr_any;
  logic [N-1:0][TRG_W-1:0]   cfg_q;
  logic [N-1:0][TRG_W-1:0]   cfg_nxt;
  logic [N-1:0]              cfg_we;
  logic                      pend_wr;
  logic [N-1:0]              pend_clr;
  logic [N-1:0]              pend_nxt;
  logic                      mask_we;
  logic [N-1:0]              mask_nxt;
  logic [NCFG-1:0][DATA_W-1:0] cfg_word;

  assign wr_any = bus_sel & bus_wr;

  for (genvar g = 0; g < N; g++) begin : g_cfg
    localparam int R = g / SLOTS;
    localparam int S = g % SLOTS;
    assign cfg_we[g]  = wr_any & (bus_addr == ADDR_W'(R));
    assign cfg_nxt[g] = bus_wdata[S*NIB_W +: TRG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (cfg_we[i]) cfg_q[i] <= cfg_nxt[i];
      end
    end
  end

  assign cfg_flat = cfg_q;

  // pending: clear on written ones, event has priority
  assign pend_wr  = wr_any & (bus_addr == ADDR_W'(PEND_ADDR));
  assign pend_clr = pend_wr ? bus_wdata[N-1:0] : '0;
  assign pend_nxt = ((pend_q & ~pend_clr) | evt) & EXT_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

  assign mask_we  = wr_any & (bus_addr == ADDR_W'(MASK_ADDR));
  assign mask_nxt = bus_wdata[N-1:0] & EXT_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= EXT_BITS;
    else if (mask_we) mask_q <= mask_nxt;
  end

  for (genvar r = 0; r < NCFG; r++) begin : g_word
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (r*SLOTS + s < N) begin : g_used
        assign cfg_word[r][s*NIB_W +: NIB_W] = {1'b0, cfg_q[r*SLOTS + s]};
      end else begin : g_empty
        assign cfg_word[r][s*NIB_W +: NIB_W] = '0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      for (int r = 0; r < NCFG; r++) begin
        if (bus_addr == ADDR_W'(r)) bus_rdata = cfg_word[r];
      end
      if (bus_addr == ADDR_W'(PEND_ADDR)) bus_rdata = DATA_W'(pend_q);
      if (bus_addr == ADDR_W'(MASK_ADDR)) bus_rdata = DATA_W'(mask_q);
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/eirq_top.sv
module eirq_top
  import eirq_pkg::*;
#(
  parameter int   NUM_PINS    = 24,
  parameter int   NUM_DIRECT  = 4,
  parameter int   LO_GRP_LAST = 7,
  parameter logic PIN_IDLE    = 1'b1,
  localparam int  NCFG        = (NUM_PINS + SLOTS - 1) / SLOTS,
  localparam int  ADDR_W      = $clog2(NCFG + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   ext_pin,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_DIRECT-1:0] irq_direct,
  output logic                  irq_grp_lo,
  output logic                  irq_grp_hi
);
  logic                      rst_n_sync;
  logic [NUM_PINS-1:0]       pin_s;
  logic [NUM_PINS-1:0]       evt;
  logic [NUM_PINS*TRG_W-1:0] cfg_flat;
  logic [NUM_PINS-1:0]       pend_q;
  logic [NUM_PINS-1:0]       mask_q;

  eirq_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  eirq_sync #(.N(NUM_PINS), .IDLE(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d     (ext_pin),
    .q     (pin_s)
  );

  eirq_detect #(.N(NUM_PINS), .IDLE(PIN_IDLE)) u_det (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .lvl      (pin_s),
    .cfg_flat (cfg_flat),
    .evt      (evt)
  );

  eirq_regs #(.N(NUM_PINS), .NDIR(NUM_DIRECT), .NCFG(NCFG), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt       (evt),
    .cfg_flat  (cfg_flat),
    .pend_q    (pend_q),
    .mask_q    (mask_q)
  );

  assign irq_direct = evt[NUM_DIRECT-1:0];
  assign irq_grp_lo = |(pend_q[LO_GRP_LAST:NUM_DIRECT] & ~mask_q[LO_GRP_LAST:NUM_DIRECT]);
  assign irq_grp_hi = |(pend_q[NUM_PINS-1:LO_GRP_LAST+1] & ~mask_q[NUM_PINS-1:LO_GRP_LAST+1]);

  logic unused_low;
  assign unused_low = ^{pend_q[NUM_DIRECT-1:0], mask_q[NUM_DIRECT-1:0]};
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk
  import eirq_pkg::*;
#(
  parameter int N      = 24,
  parameter int NDIR   = 4,
  parameter int LO     = 7,
  parameter int NCFG   = 3,
  parameter int ADDR_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N-1:0]       evt,
  input logic [N-1:0]       pend_q,
  input logic [N-1:0]       mask_q,
  input logic [N*TRG_W-1:0] cfg_flat,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NDIR-1:0]    irq_direct,
  input logic               irq_grp_lo,
  input logic               irq_grp_hi
);
  localparam int PEND_ADDR = NCFG;

  for (genvar g = NDIR; g < N; g++) begin : g_ext
    // R4
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[g]) |-> $past(evt[g]));
    // R5
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[g]) |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(PEND_ADDR) && bus_wdata[g]));
  end

  for (genvar j = 0; j < NDIR; j++) begin : g_dir
    logic [TRG_W-1:0] code;
    logic             single_edge;
    assign code        = cfg_flat[j*TRG_W +: TRG_W];
    assign single_edge = (code[2:1] == 2'b01) || (code[2:1] == 2'b10);
    // R3
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (single_edge && irq_direct[j]) |=> (!$stable(code) || !irq_direct[j]));
  end

  // R6
  lo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q[LO:NDIR]) |-> !irq_grp_lo);

  // R7
  hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q[N-1:LO+1]) |-> !irq_grp_hi);

  // R8
  dir_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(PEND_ADDR)) |-> (bus_rdata[NDIR-1:0] == '0));
endmodule

bind eirq_top eirq_chk #(
  .N(NUM_PINS), .NDIR(NUM_DIRECT), .LO(LO_GRP_LAST), .NCFG(NCFG), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .evt        (evt),
  .pend_q     (pend_q),
  .mask_q     (mask_q),
  .cfg_flat   (cfg_flat),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_direct (irq_direct),
  .irq_grp_lo (irq_grp_lo),
  .irq_grp_hi (irq_grp_hi)
);

// File: tb/eirq_top_tb.sv
module eirq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] pins;
  logic        bus_sel;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_direct;
  logic        irq_grp_lo;
  logic        irq_grp_hi;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  eirq_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_pin    (pins),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_direct (irq_direct),
    .irq_grp_lo (irq_grp_lo),
    .irq_grp_hi (irq_grp_hi)
  );

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // every pin on rising edge (code 100) except pin p, which gets code c
  function automatic logic [31:0] cfgw(input int r, input int p, input logic [2:0] c);
    logic [31:0] w = '0;
    for (int s = 0; s < 8; s++) begin
      w[4*s +: 4] = {1'b0, ((r*8 + s) == p) ? c : 3'b100};
    end
    return w;
  endfunction

  // R4 R6 R7 R8: whole pending word plus both group lines
  task automatic chk_pend(input string req, input int p, input bit e);
    logic [31:0] d;
    rd(3'd3, d);
    chk({req, " R4 pending word"}, d, (p >= 4 && e) ? (32'd1 << p) : 32'd0);
    chk({req, " R6 lower group"}, 32'(irq_grp_lo), 32'(p >= 4 && p <= 7 && e));
    chk({req, " R7 upper group"}, 32'(irq_grp_hi), 32'(p >= 8 && e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; pins = '1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R9 reset state
    rd(3'd4, d); chk("R9 mask reset", d, 32'h00FF_FFF0);
    rd(3'd3, d); chk("R9 pending reset", d, 32'h0);
    for (int r = 0; r < 3; r++) begin
      rd(3'(r), d); chk("R9 cfg reset", d, 32'h0);
    end
    chk("R9 outputs idle", {28'h0, irq_direct}, 32'h0);
    chk("R9 groups idle", {30'h0, irq_grp_lo, irq_grp_hi}, 32'h0);

    // R1 unused nibble bit
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R1 nibble bit 3 reads zero", d, 32'h7777_7777);

    // R2 R3 sweep over every pin and every code
    wr(3'd4, 32'h0);
    for (int p = 0; p < 24; p++) begin
      for (int c = 0; c < 8; c++) begin
        logic [2:0] code;
        bit lo_l, hi_l;
        int kind, cnt, ef, er;
        code = 3'(c);
        lo_l = (code == 3'b000);
        hi_l = (code == 3'b001);
        kind = int'(code[2:1]);
        for (int r = 0; r < 3; r++) wr(3'(r), cfgw(r, p, code));
        rd(3'(p / 8), d);
        chk("R1 cfg readback", d, cfgw(p / 8, p, code));
        wr(3'd3, 32'hFFFF_FFFF);
        chk_pend("R5 clear with high level held", p, hi_l);

        // falling transition: R2 R3
        ef = lo_l ? 3 : hi_l ? 1 : (kind == 2) ? 0 : 1;
        pins[p] = 1'b0;
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
          step(1);
          if (p < 4) cnt += int'(irq_direct[p]);
        end
        if (p < 4) chk("R2 R3 direct cycles after fall", 32'(cnt), 32'(ef));
        chk_pend("R2 after fall", p, lo_l || hi_l || kind == 1 || kind == 3);
        wr(3'd3, 32'hFFFF_FFFF);
        chk_pend("R5 clear with low level held", p, lo_l);

        // rising transition
        er = hi_l ? 3 : lo_l ? 1 : (kind == 1) ? 0 : 1;
        pins[p] = 1'b1;
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
          step(1);
          if (p < 4) cnt += int'(irq_direct[p]);
        end
        if (p < 4) chk("R2 R3 direct cycles after rise", 32'(cnt), 32'(er));
        chk_pend("R2 after rise", p, lo_l || hi_l || kind == 2 || kind == 3);
        wr(3'd3, 32'hFFFF_FFFF);
        chk_pend("R5 final clear", p, hi_l);
      end
    end

    // R4 R5 R6 R7 R8 masking and selective clearing: pins 5 and 12 on falling edge
    for (int r = 0; r < 3; r++) wr(3'(r), 32'h4444_4444);
    wr(3'd0, 32'h4424_4444);
    wr(3'd1, 32'h4442_4444);
    wr(3'd3, 32'hFFFF_FFFF);
    pins[5] = 1'b0; pins[12] = 1'b0;
    step(4);
    rd(3'd3, d); chk("R4 two pending", d, 32'h0000_1020);
    chk("R6 lower live", 32'(irq_grp_lo), 32'd1);
    chk("R7 upper live", 32'(irq_grp_hi), 32'd1);
    wr(3'd4, 32'h0000_0020);
    chk("R6 lower masked", 32'(irq_grp_lo), 32'd0);
    chk("R7 upper unaffected", 32'(irq_grp_hi), 32'd1);
    rd(3'd3, d); chk("R4 pending kept under mask", d, 32'h0000_1020);
    wr(3'd4, 32'h0000_1020);
    chk("R7 upper masked", 32'(irq_grp_hi), 32'd0);
    wr(3'd4, 32'h0000_000F);
    rd(3'd4, d); chk("R8 low mask bits read zero", d, 32'h0);
    chk("R6 lower unmasked", 32'(irq_grp_lo), 32'd1);
    wr(3'd3, 32'h0000_0020);
    rd(3'd3, d); chk("R5 zeros leave bits", d, 32'h0000_1000);
    chk("R6 lower cleared", 32'(irq_grp_lo), 32'd0);
    chk("R7 upper still live", 32'(irq_grp_hi), 32'd1);
    pins[5] = 1'b1; pins[12] = 1'b1;
    step(4);

    // R10 unused addresses
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); chk("R10 unused address reads zero", d, 32'h0);
    end
    rd(3'd4, d); chk("R10 mask untouched", d, 32'h0);
    rd(3'd0, d); chk("R10 cfg untouched", d, 32'h4424_4444);
    rd(3'd3, d); chk("R10 pending untouched", d, 32'h0000_1000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule